// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous static memory with a shared data path, split here into a data-in bus, a data-out bus and an output-drive qualifier. All synchronous inputs are registered on the rising clock edge. Read data then passes through a second output register. An access begins when either of two active-low address strobes is asserted. After that, the word address inside an aligned group of four comes from an internal two-bit burst counter, which the advance input steps. The counter order is either linear or interleaved, chosen by a static mode input.

Writes are self-timed. Byte lanes are picked by active-low per-lane enables, which count only when the byte-write enable is active. A global write input overrides the lane enables. The output drive qualifier is gated asynchronously by the output enable. When the part is deselected, the drivers stay on for one extra cycle. A sleep input parks the device in a deselected, undriven state. The array depth is a parameter, so the block can be simulated at a modest size.

Top module: `pburst_sram`

## Requirements
- R1: A read captured at clock edge N shows its word on `dout` after edge N+1, with `dout_en` high (given `oe_n` low).
- R2: A write started by the controller strobe with `gw_n` high and `bwe_n` low updates byte lane i (bits 8i+7..8i) only where `bw_n[i]` is 0. Other lanes keep their contents.
- R3: With `gw_n` low, a write updates all four lanes whatever `bwe_n` and `bw_n` are.
- R4: In linear mode (`burst_lin`=1), each cycle with `adv_n` low and no strobe moves the access to the next word, with the two low address bits being (start + count) mod 4. The upper address bits do not change.
- R5: In interleaved mode (`burst_lin`=0), the two low address bits are the start bits XOR the count.
- R6: A cycle with no strobe and `adv_n` high repeats the access at the current burst address.
- R7: Asserting the controller strobe in the middle of a burst restarts the burst at the newly presented address.
- R8: The processor strobe is ignored while `ce_pri_n` is high. A start by the processor strobe is always a read, and any write inputs in that cycle are ignored.
- R9: After a deselect is captured at edge N, `dout_en` stays high and `dout` holds its word after edge N+1. Both go off after edge N+2 if the part is still deselected.
- R10: After a write is executed, `dout_en` is low until a read is executed.
- R11: `dout_en` is low at any time `oe_n` is high, without waiting for a clock edge.
- R12: While `sleep` is high, all synchronous inputs are ignored and the outputs are off from the next edge. After sleep ends, the part stays deselected until a strobe starts an access.
- R13: After reset, the part is deselected and `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, loaded on a strobe |
| din | input | DW | Write data |
| dout | output | DW | Registered read data |
| dout_en | output | 1 | Output drive qualifier |
| ce_pri_n | input | 1 | Primary chip enable, active low; also gates the processor strobe |
| ce_hi | input | 1 | Depth-expansion enable, active high |
| ce_lo_n | input | 1 | Depth-expansion enable, active low |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctrl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | NB | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Low-power park request |

## Verification
The bench walks both burst orders from a base address whose low bits are not zero, so the wrap inside the group of four matters. A counter that carried into the upper bits, or that mixed up the two orders, would return a word from the wrong address. It times the extra drive cycle after a deselect exactly: a design that switched off at once, or that stayed on, would fail the enable check one edge later or one edge earlier. Partial byte writes are read back against a merged expected word, which exposes lane-order or mask-polarity mistakes. A processor-strobe start that carries write inputs is checked to leave memory untouched. The bench also enters sleep while the drivers are on, checking that the outputs shut off and that a strobe in the same cycle does not start a read.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_RD    = 2'd1,
    OP_WR    = 2'd2,
    OP_SLP   = 2'd3
  } pbs_op_e;
endpackage

// File: rtl/pbs_burst.sv
// Burst address generator: base register plus a two-bit beat counter.
module pbs_burst #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          lin,
  input  logic [AW-1:0] ld_addr,
  output logic [AW-1:0] cur_addr
);
  localparam int CW = 2;

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_use;
  logic [CW-1:0] lo;

  always_comb begin
    cnt_use = step ? cnt_q + 1'b1 : cnt_q;
    lo      = lin ? base_q[CW-1:0] + cnt_use : base_q[CW-1:0] ^ cnt_use;
    cur_addr = load ? ld_addr : {base_q[AW-1:CW], lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= ld_addr;
      cnt_q  <= '0;
    end else if (step) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pbs_ctrl.sv
// Input decode and the registered-input stage.
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_pri_n,
  input  logic          ce_hi,
  input  logic          ce_lo_n,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic          sleep,
  input  logic [DW-1:0] din,
  input  logic [AW-1:0] cur_addr,
  output logic          load,
  output logic          step,
  output pbs_op_e       op_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output logic [NB-1:0] mask_q
);
  logic          active_q;
  logic          active_d;
  logic          sel;
  logic          go_ctrl;
  logic          go_proc;
  logic          wr_req;
  logic [NB-1:0] mask_d;
  pbs_op_e       op_d;

  always_comb begin
    sel     = !ce_pri_n && ce_hi && !ce_lo_n;
    go_ctrl = !strb_ctrl_n;
    go_proc = !strb_proc_n && !ce_pri_n && !go_ctrl;
    mask_d  = !gw_n ? {NB{1'b1}} : (!bwe_n ? ~bw_n : '0);
    wr_req  = |mask_d;
    load    = 1'b0;
    step    = 1'b0;
    active_d = active_q;
    op_d    = OP_DESEL;
    if (sleep) begin
      op_d     = OP_SLP;
      active_d = 1'b0;
    end else if (go_ctrl || go_proc) begin
      if (sel) begin
        load     = 1'b1;
        active_d = 1'b1;
        op_d     = (go_ctrl && wr_req) ? OP_WR : OP_RD;
      end else begin
        active_d = 1'b0;
      end
    end else if (active_q) begin
      step = !adv_n;
      op_d = wr_req ? OP_WR : OP_RD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      op_q     <= OP_DESEL;
      addr_q   <= '0;
      din_q    <= '0;
      mask_q   <= '0;
    end else begin
      active_q <= active_d;
      op_q     <= op_d;
      addr_q   <= cur_addr;
      din_q    <= din;
      mask_q   <= (op_d == OP_WR) ? mask_d : '0;
    end
  end

  // R8: a processor strobe without the primary enable starts nothing
  a_r8_proc_gated: assert property (@(posedge clk) disable iff (rst)
    (strb_ctrl_n && !strb_proc_n && ce_pri_n && !active_q && !sleep) |=> (op_q == OP_DESEL));

  // R12: sleep overrides every strobe
  a_r12_sleep_wins: assert property (@(posedge clk) disable iff (rst)
    (sleep && !strb_ctrl_n) |=> (op_q == OP_SLP));
endmodule

// File: rtl/pbs_array.sv
// Byte-lane memory with registered read data (the output register).
module pbs_array
  import pbs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int NB    = DW / 8
) (
  input  logic          clk,
  input  pbs_op_e       op_q,
  input  logic [AW-1:0] addr_q,
  input  logic [DW-1:0] din_q,
  input  logic [NB-1:0] mask_q,
  output logic [DW-1:0] rdata
);
  localparam int BW = DW / NB;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BW-1:0] mem [DEPTH];
    logic [BW-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (op_q == OP_WR && mask_q[g])
        mem[addr_q] <= din_q[g*BW +: BW];
      if (op_q == OP_RD)
        rd_q <= mem[addr_q];
    end

    assign rdata[g*BW +: BW] = rd_q;
  end
endmodule

// File: rtl/pbs_out.sv
// Output drive pipeline with one extra cycle of drive on deselect.
module pbs_out
  import pbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  pbs_op_e op_q,
  input  logic    oe_n,
  output logic    dout_en
);
  logic on_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b0;
      pend_q <= 1'b1;
    end else begin
      unique case (op_q)
        OP_RD: begin
          on_q   <= 1'b1;
          pend_q <= 1'b0;
        end
        OP_WR: begin
          on_q   <= 1'b0;
          pend_q <= 1'b0;
        end
        OP_DESEL: begin
          if (pend_q) on_q <= 1'b0;
          pend_q <= 1'b1;
        end
        OP_SLP: begin
          on_q   <= 1'b0;
          pend_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign dout_en = on_q && !oe_n;

  // R1: an executed read turns the drivers on
  a_r1_read_drives: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_RD) |=> on_q);
  // R10: an executed write turns the drivers off
  a_r10_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_WR) |=> !on_q);
  // R9: first deselect cycle keeps the drive state
  a_r9_desel_hold: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_DESEL && !pend_q) |=> $stable(on_q));
  // R12: sleep shuts the drivers
  a_r12_sleep_off: assert property (@(posedge clk) disable iff (rst)
    (op_q == OP_SLP) |=> !on_q);
endmodule

// File: rtl/pburst_sram.sv
module pburst_sram
  import pbs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 32,
  parameter int NB    = DW / 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          ce_pri_n,
  input  logic          ce_hi,
  input  logic          ce_lo_n,
  input  logic          strb_proc_n,
  input  logic          strb_ctrl_n,
  input  logic          adv_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [NB-1:0] bw_n,
  input  logic          oe_n,
  input  logic          burst_lin,
  input  logic          sleep
);
  logic          load;
  logic          step;
  logic [AW-1:0] cur_addr;
  pbs_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic [NB-1:0] mask_q;

  pbs_burst #(.AW(AW)) u_burst (
    .clk(clk), .rst(rst), .load(load), .step(step), .lin(burst_lin),
    .ld_addr(addr), .cur_addr(cur_addr)
  );

  pbs_ctrl #(.AW(AW), .DW(DW), .NB(NB)) u_ctrl (
    .clk(clk), .rst(rst), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .sleep(sleep), .din(din),
    .cur_addr(cur_addr), .load(load), .step(step), .op_q(op_q),
    .addr_q(addr_q), .din_q(din_q), .mask_q(mask_q)
  );

  pbs_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .NB(NB)) u_array (
    .clk(clk), .op_q(op_q), .addr_q(addr_q), .din_q(din_q), .mask_q(mask_q),
    .rdata(dout)
  );

  pbs_out u_out (
    .clk(clk), .rst(rst), .op_q(op_q), .oe_n(oe_n), .dout_en(dout_en)
  );
endmodule

// File: tb/pburst_sram_tb.sv
module pburst_sram_tb;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic [DW-1:0] din;
  logic [DW-1:0] dout;
  logic          dout_en;
  logic          ce_pri_n, ce_hi, ce_lo_n;
  logic          strb_proc_n, strb_ctrl_n, adv_n;
  logic          gw_n, bwe_n;
  logic [NB-1:0] bw_n;
  logic          oe_n, burst_lin, sleep;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pburst_sram u_dut (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
    .burst_lin(burst_lin), .sleep(sleep)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return 32'hC3A50000 ^ ({22'd0, a} * 32'h01030507);
  endfunction

  function automatic logic [AW-1:0] bexp(input logic [AW-1:0] b, input int k, input logic lin);
    logic [1:0] kk;
    kk = 2'(k);
    return lin ? {b[AW-1:2], 2'(b[1:0] + kk)} : {b[AW-1:2], b[1:0] ^ kk};
  endfunction

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chk32(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic quiet();
    strb_ctrl_n = 1'b1; strb_proc_n = 1'b1; adv_n = 1'b1;
    ce_pri_n = 1'b0; ce_hi = 1'b1; ce_lo_n = 1'b0;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; sleep = 1'b0;
  endtask

  task automatic desel();
    quiet();
    strb_ctrl_n = 1'b0; ce_pri_n = 1'b1;
  endtask

  task automatic start_rd(input logic [AW-1:0] a);
    quiet();
    strb_ctrl_n = 1'b0; addr = a;
  endtask

  task automatic start_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    quiet();
    strb_ctrl_n = 1'b0; addr = a; din = d; gw_n = 1'b0;
  endtask

  task automatic adv();
    quiet();
    adv_n = 1'b0;
  endtask

  task automatic settle();
    desel(); cyc(); cyc(); cyc();
  endtask

  task automatic t_fill();
    for (int a = 0; a < 16; a++) begin
      start_wr(AW'(a), pat(AW'(a)));
      cyc();
    end
    settle();
  endtask

  task automatic t_single();
    start_rd(10'd5); cyc();
    desel(); cyc();
    chk32("R1 read data", dout, pat(10'd5));
    chk1("R1 drive on", dout_en, 1'b1);
    oe_n = 1'b1; #1;
    chk1("R11 oe high blocks drive", dout_en, 1'b0);
    oe_n = 1'b0; #1;
    chk1("R11 oe low restores drive", dout_en, 1'b1);
    cyc();
    chk1("R9 extra drive cycle", dout_en, 1'b1);
    chk32("R9 data held", dout, pat(10'd5));
    cyc();
    chk1("R9 drive off", dout_en, 1'b0);
    settle();
  endtask

  task automatic t_burst(input logic [AW-1:0] b, input logic lin);
    burst_lin = lin;
    start_rd(b); cyc();
    for (int k = 1; k < 4; k++) begin
      adv(); cyc();
      chk32(lin ? "R4 linear beat" : "R5 interleaved beat", dout, pat(bexp(b, k - 1, lin)));
    end
    desel(); cyc();
    chk32(lin ? "R4 linear last beat" : "R5 interleaved last beat", dout, pat(bexp(b, 3, lin)));
    settle();
    burst_lin = 1'b1;
  endtask

  task automatic t_suspend();
    start_rd(10'd12); cyc();
    quiet(); cyc();
    chk32("R6 first beat", dout, pat(10'd12));
    quiet(); cyc();
    chk32("R6 suspended beat", dout, pat(10'd12));
    adv(); cyc();
    chk32("R6 still held", dout, pat(10'd12));
    desel(); cyc();
    chk32("R6 resumed advance", dout, pat(10'd13));
    settle();
  endtask

  task automatic t_restart();
    start_rd(10'd0); cyc();
    adv(); cyc();
    chk32("R7 beat0", dout, pat(10'd0));
    start_rd(10'd10); cyc();
    chk32("R7 beat1", dout, pat(10'd1));
    adv(); cyc();
    chk32("R7 new base", dout, pat(10'd10));
    desel(); cyc();
    chk32("R7 new base next", dout, pat(10'd11));
    settle();
  endtask

  task automatic t_bytes();
    logic [DW-1:0] e3;
    e3 = (pat(10'd3) & 32'hFF00FF00) | (32'h11223344 & 32'h00FF00FF);
    quiet(); strb_ctrl_n = 1'b0; addr = 10'd3; din = 32'h11223344;
    bwe_n = 1'b0; bw_n = 4'b1010; cyc();
    start_rd(10'd3); cyc();
    desel(); cyc();
    chk32("R2 lanes 0 and 2 written", dout, e3);
    settle();
    quiet(); strb_ctrl_n = 1'b0; addr = 10'd4; din = 32'hDEADBEEF;
    gw_n = 1'b0; bwe_n = 1'b0; bw_n = 4'b1110; cyc();
    start_rd(10'd4); cyc();
    desel(); cyc();
    chk32("R3 global write all lanes", dout, 32'hDEADBEEF);
    settle();
    // R8: processor start with write inputs reads instead
    quiet(); strb_proc_n = 1'b0; addr = 10'd3; din = 32'h0; gw_n = 1'b0; cyc();
    desel(); cyc();
    chk32("R8 proc start reads", dout, e3);
    chk1("R8 proc start drives", dout_en, 1'b1);
    settle();
    start_rd(10'd3); cyc();
    desel(); cyc();
    chk32("R8 memory untouched", dout, e3);
    settle();
    quiet(); ce_pri_n = 1'b1; strb_proc_n = 1'b0; addr = 10'd5; cyc();
    quiet(); ce_pri_n = 1'b1; cyc();
    chk1("R8 gated proc strobe no drive", dout_en, 1'b0);
    cyc();
    chk1("R8 gated proc strobe still off", dout_en, 1'b0);
    settle();
  endtask

  task automatic t_wr_off();
    start_rd(10'd2); cyc();
    start_wr(10'd14, pat(10'd14)); cyc();
    chk1("R10 read drives", dout_en, 1'b1);
    chk32("R10 read data", dout, pat(10'd2));
    desel(); cyc();
    chk1("R10 write turns drive off", dout_en, 1'b0);
    cyc();
    chk1("R10 stays off", dout_en, 1'b0);
    settle();
  endtask

  task automatic t_sleep();
    start_rd(10'd5); cyc();
    start_rd(10'd6); sleep = 1'b1; cyc();
    chk1("R12 drive before sleep", dout_en, 1'b1);
    cyc();
    chk1("R12 sleep drive off", dout_en, 1'b0);
    chk32("R12 strobe ignored", dout, pat(10'd5));
    quiet(); cyc();
    chk1("R12 after wake off", dout_en, 1'b0);
    cyc();
    chk1("R12 after wake deselected", dout_en, 1'b0);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    quiet();
    addr = '0; din = '0; oe_n = 1'b0; burst_lin = 1'b1;
    rst = 1'b1;
    cyc(); cyc();
    rst = 1'b0;
    chk1("R13 reset drive off", dout_en, 1'b0);
    quiet(); cyc();
    chk1("R13 deselected after reset", dout_en, 1'b0);
    t_fill();
    t_single();
    t_burst(10'd9, 1'b1);
    t_burst(10'd9, 1'b0);
    t_burst(10'd6, 1'b0);
    t_suspend();
    t_restart();
    t_bytes();
    t_wr_off();
    t_sleep();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule